// File: doc/BRIEF.md
# Activity LED Indicator Controller

This block produces the drive for one active-low, open-drain activity indicator belonging to one port of a media converter. It runs from the 25 MHz reference clock. While the port sees no 10 or 100 Mb/s line signal, the indicator simply mirrors the auto-negotiation burst activity strobe. Once a line speed is detected, the indicator instead shows packet activity. Each packet strobe holds the indicator on for a stretched window so that short frames remain visible.

The stretch is timed by a free-running prescaler that counts reference cycles from reset. A prescaler tick occurs on every cycle in which the low L bits of the prescaler are all ones. L is 15 in normal mode, giving a period of about 1.31 ms. L is 12 when the test-fast input is high, giving about 164 µs. After the last packet strobe, the indicator stays on until two ticks have passed. When the indicator is not being pulled low, both outputs are zero, which models a high-impedance pad.

Top module: `actled_indicator`

## Requirements
- R1: A synchronous active-low reset clears the stretch state and forces `ledPullLow` and `ledOe` to 0 on the next clock. After reset is released, a line speed with no packet strobe keeps both outputs at 0.
- R2: With `speedSense` equal to 2'b00 (no signal) or 2'b11 (reserved, treated as no signal), `ledPullLow` and `ledOe` equal the value `anegAct` had on the previous clock.
- R3: Packet strobes that arrive while no speed is detected are ignored and leave no stretch behind once a speed appears.
- R4: With `speedSense` equal to 2'b01 (10 Mb/s) or 2'b10 (100 Mb/s), `anegAct` has no effect on the outputs.
- R5: With a speed detected, a `pktAct` strobe sets both outputs to 1 on the next clock.
- R6: With `testFast` at 0, a single packet strobe keeps the outputs at 1 for between 2^15+2 and 2^16+1 clocks inclusive, counted from the first clock at which they are set.
- R7: With `testFast` at 1, the tick period is 2^12 clocks, so a single strobe gives a width between 4098 and 8193 clocks. A strobe sampled one clock after a tick gives exactly 8192 clocks.
- R8: A packet strobe that arrives during an active stretch restarts the two-tick count, so the indicator stays on continuously.
- R9: When a packet strobe is sampled on the same clock as a prescaler tick, the restart wins and the tick is not counted, giving a width of exactly two full periods plus one (8193 clocks in test-fast mode).
- R10: Losing the detected speed clears the stretch at once. The outputs then follow `anegAct`, and a later return of the speed without a new strobe shows nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rstN | input | 1 | Synchronous active-low reset |
| speedSense | input | 2 | Detected line speed: 00 none, 01 10 Mb/s, 10 100 Mb/s, 11 reserved (none) |
| anegAct | input | 1 | Auto-negotiation burst activity strobe |
| pktAct | input | 1 | Data-packet activity strobe |
| testFast | input | 1 | Selects the short stretch period |
| ledPullLow | output | 1 | 1 pulls the indicator pad low |
| ledOe | output | 1 | 1 enables the pad driver; 0 models high impedance |

## Verification
Two functions can fall in the same cycle: a new packet strobe, which reloads the hold count, and a prescaler tick, which decrements it. The bench finds the tick phase by recording the clock on which an earlier stretch ended. It then schedules a strobe exactly on a later tick clock and another strobe one clock after a tick. The results are judged by exact widths of 8193 and 8192 clocks. A design that lets the tick win, or that decrements the freshly loaded count, comes out one period short.

// File: rtl/actled_pkg.sv
package actled_pkg;

  typedef enum logic [1:0] {
    SPD_NONE = 2'b00,
    SPD_10   = 2'b01,
    SPD_100  = 2'b10,
    SPD_RSVD = 2'b11
  } speed_e;

  typedef struct packed {
    logic load;
    logic clear;
    logic fastMode;
  } stretchCtrl_t;

endpackage

// File: rtl/actled_stretch.sv
module actled_stretch
  import actled_pkg::*;
#(
  parameter int SLOW_LOG2  = 15,
  parameter int FAST_LOG2  = 12,
  parameter int HOLD_TICKS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  stretchCtrl_t ctrl,
  output logic         stretchOn
);

  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(HOLD_TICKS);
  localparam logic [SLOW_LOG2-1:0] UPPER_ONES =
    {{(SLOW_LOG2-FAST_LOG2){1'b1}}, {FAST_LOG2{1'b0}}};

  logic [SLOW_LOG2-1:0] preCnt;
  logic [CNT_W-1:0]     holdCnt;
  logic                 tick;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    if (ctrl.fastMode) tick = &(preCnt | UPPER_ONES);
    else               tick = &preCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear)          holdCnt <= '0;
    else if (ctrl.load)               holdCnt <= HOLD_VAL;
    else if (tick && holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
  end

  assign stretchOn = (holdCnt != '0);

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= HOLD_VAL); // R6
  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.clear) |=> holdCnt == HOLD_VAL); // R8
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.clear && tick && stretchOn) |=>
      (holdCnt + CNT_W'(1)) == $past(holdCnt)); // R6
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.clear && !tick) |=> $stable(holdCnt)); // R6
  AST_CLEAR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> !stretchOn); // R10

endmodule

// File: rtl/actled_ctrl.sv
module actled_ctrl
  import actled_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  speed_e       speed,
  input  logic         anegAct,
  input  logic         pktAct,
  input  logic         testFast,
  input  logic         stretchOn,
  output stretchCtrl_t ctrl,
  output logic         ledPullLow,
  output logic         ledOe
);

  logic linkUp;
  logic showNext;
  logic ledDrive;

  assign linkUp = (speed == SPD_10) || (speed == SPD_100);

  always_comb begin
    ctrl.load     = linkUp && pktAct;
    ctrl.clear    = !linkUp;
    ctrl.fastMode = testFast;
  end

  assign showNext = linkUp ? (pktAct || stretchOn) : anegAct;

  always_ff @(posedge clk) begin
    if (!rstN) ledDrive <= 1'b0;
    else       ledDrive <= showNext;
  end

  assign ledPullLow = ledDrive;
  assign ledOe      = ledDrive;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> !ledOe); // R1
  AST_ANEG_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    !linkUp |=> ledPullLow == $past(anegAct)); // R2
  AST_NOLINK_NO_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    !linkUp |=> !stretchOn); // R3
  AST_ANEG_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (linkUp && !pktAct && !stretchOn) |=> !ledOe); // R4
  AST_PKT_SHOWN: assert property (@(posedge clk) disable iff (!rstN)
    (linkUp && pktAct) |=> (ledPullLow && ledOe)); // R5

endmodule

// File: rtl/actled_indicator.sv
module actled_indicator
  import actled_pkg::*;
#(
  parameter int SLOW_LOG2  = 15,
  parameter int FAST_LOG2  = 12,
  parameter int HOLD_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] speedSense,
  input  logic       anegAct,
  input  logic       pktAct,
  input  logic       testFast,
  output logic       ledPullLow,
  output logic       ledOe
);

  stretchCtrl_t ctrl;
  logic         stretchOn;

  actled_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .speed     (speed_e'(speedSense)),
    .anegAct   (anegAct),
    .pktAct    (pktAct),
    .testFast  (testFast),
    .stretchOn (stretchOn),
    .ctrl      (ctrl),
    .ledPullLow(ledPullLow),
    .ledOe     (ledOe)
  );

  actled_stretch #(
    .SLOW_LOG2 (SLOW_LOG2),
    .FAST_LOG2 (FAST_LOG2),
    .HOLD_TICKS(HOLD_TICKS)
  ) u_stretch (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .stretchOn(stretchOn)
  );

endmodule

// File: tb/test_actled_indicator.sv
module test_actled_indicator;

  localparam int FAST_P = 4096;
  localparam int SLOW_P = 32768;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] speedSense = 2'b00;
  logic       anegAct = 1'b0;
  logic       pktAct = 1'b0;
  logic       testFast = 1'b1;
  logic       ledPullLow;
  logic       ledOe;

  int checks = 0;
  int errors = 0;
  int edgeCount = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) edgeCount++;

  actled_indicator i_actled_indicator (
    .clk       (clk),
    .rstN      (rstN),
    .speedSense(speedSense),
    .anegAct   (anegAct),
    .pktAct    (pktAct),
    .testFast  (testFast),
    .ledPullLow(ledPullLow),
    .ledOe     (ledOe)
  );

  // {speed[1:0], aneg, pkt, expected led}
  localparam logic [4:0] VECS [0:9] = '{
    5'b00_1_0_1,  // R2 aneg shown
    5'b00_0_0_0,  // R2
    5'b11_1_0_1,  // R2 reserved code = none
    5'b00_0_1_0,  // R3 pkt ignored without speed
    5'b01_0_0_0,  // R3 no residual stretch
    5'b10_1_0_0,  // R4 aneg ignored with speed
    5'b01_1_1_1,  // R5 packet shown
    5'b10_0_0_1,  // R5 stretch holds
    5'b00_0_0_0,  // R10 speed lost
    5'b10_0_0_0   // R10 stretch was cleared
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // Strobe pktAct for one clock, then measure how many clocks the LED stays on.
  task automatic pulseMeasure(input string req, output int width, output int lastEdge);
    pktAct = 1'b1;
    @(negedge clk);
    pktAct = 1'b0;
    check({req, " R5 set"}, int'(ledPullLow && ledOe), 1);
    width = 0;
    lastEdge = edgeCount;
    while (ledPullLow) begin
      width++;
      lastEdge = edgeCount;
      @(negedge clk);
    end
  endtask

  task automatic waitForEdge(input int k);
    while (edgeCount != k - 1) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w, last, tickEdge, k;
    repeat (3) @(negedge clk);
    check("R1 reset pull", int'(ledPullLow), 0);
    check("R1 reset oe", int'(ledOe), 0);
    rstN = 1'b1;

    for (int i = 0; i < 10; i++) begin
      speedSense = VECS[i][4:3];
      anegAct    = VECS[i][2];
      pktAct     = VECS[i][1];
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R10 vector %0d pull", i), int'(ledPullLow), int'(VECS[i][0]));
      check($sformatf("R2/R3/R4/R5/R10 vector %0d oe", i), int'(ledOe), int'(VECS[i][0]));
    end
    anegAct = 1'b0;
    pktAct = 1'b0;
    speedSense = 2'b10;
    testFast = 1'b1;
    @(negedge clk);

    // R7 fast window
    pulseMeasure("R7", w, last);
    checkRange("R7 fast width", w, FAST_P + 2, 2 * FAST_P + 1);
    tickEdge = last;

    // R9 strobe on a tick edge
    k = tickEdge + FAST_P;
    while (k <= edgeCount + 1) k += FAST_P;
    waitForEdge(k);
    pulseMeasure("R9", w, last);
    check("R9 strobe on tick width", w, 2 * FAST_P + 1);

    // R7 strobe one clock after a tick
    k = last + FAST_P + 1;
    while (k <= edgeCount + 1) k += FAST_P;
    waitForEdge(k);
    pulseMeasure("R7", w, last);
    check("R7 strobe after tick width", w, 2 * FAST_P);

    // R8 restart during stretch
    begin
      bit dropped = 0;
      pktAct = 1'b1;
      @(negedge clk);
      pktAct = 1'b0;
      repeat (3000) begin
        if (!ledPullLow) dropped = 1;
        @(negedge clk);
      end
      check("R8 held before restart", int'(dropped), 0);
      pulseMeasure("R8", w, last);
      checkRange("R8 width after restart", w, FAST_P + 2, 2 * FAST_P + 1);
    end

    // R1 reset during stretch
    pktAct = 1'b1;
    @(negedge clk);
    pktAct = 1'b0;
    repeat (10) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset mid-stretch", int'(ledOe), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 stretch cleared by reset", int'(ledOe), 0);

    // R10 speed loss during stretch
    pktAct = 1'b1;
    @(negedge clk);
    pktAct = 1'b0;
    repeat (10) @(negedge clk);
    speedSense = 2'b00;
    @(negedge clk);
    check("R10 speed lost", int'(ledPullLow), 0);
    speedSense = 2'b01;
    @(negedge clk);
    check("R10 no stretch after return", int'(ledPullLow), 0);

    // R6 normal window
    testFast = 1'b0;
    @(negedge clk);
    pulseMeasure("R6", w, last);
    checkRange("R6 slow width", w, SLOW_P + 2, 2 * SLOW_P + 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule